// File: doc/BRIEF.md
# Coincident-Selection Bit RAM Array

This block is a small static memory of single-bit words whose storage cells sit in a two-dimensional grid. It does not decode the whole address into one long list of word lines. Instead, the address is split into a row field and a column field. Each field feeds its own small one-hot decoder. A cell is reached only where its row line and its column line are both active.

Every column has its own read/write slice, and that slice is gated by its column line. Chip select serves as the enable of the column decoder, so with chip select low no column is active and the array is neither read nor written. Writes take effect on the rising clock edge. Reads are combinational. The output carries an enable flag in place of a three-state driver, and the data output is forced to 0 whenever that flag is low.

Top module: `csel_ram`

## Requirements
- R1: The upper ROW_BITS address bits select the row and the lower COL_BITS bits select the column. The accessed cell index is row*(2**COL_BITS)+column, so with the default sizes address 4'b1001 reaches cell 9 (row 2, column 1).
- R2: When cs=1 and wr=1 at a rising clock edge, din is stored into the addressed cell.
- R3: A write changes no cell other than the addressed one.
- R4: When cs=1 and wr=0, dout equals the addressed cell's value in the same cycle, with no clock edge needed, and dout_en=1.
- R5: When cs=0, dout_en=0 and dout=0, and a clock edge with wr=1 leaves every cell unchanged.
- R6: When cs=1 and wr=1, dout_en=0 and dout=0.
- R7: While rst_n=0, every cell is cleared to 0.
- R8: At most one column line is active at a time, and none is active while cs=0. Exactly one row line is active at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears the array |
| addr | input | ROW_BITS+COL_BITS | Cell address, row field in the upper bits |
| din | input | 1 | Write data |
| wr | input | 1 | 1 = write, 0 = read |
| cs | input | 1 | Chip select, enables the column decoder |
| dout | output | 1 | Read data, 0 when not driven |
| dout_en | output | 1 | High while the output is driven for a read |

## Verification
The bench builds the block with the default ROW_BITS=2 and COL_BITS=2, which gives a 4x4 grid of 16 cells. That size is small enough for a walking single one to be written to every cell in turn while the whole array is read back after each write. This exposes any swap of the row and column fields, any fault in either decoder, and any write that disturbs a neighbour cell. It also brings every row/column pairing within reach of the chip-select-low and write-mode output checks.

// File: rtl/csel_ram.sv
module csel_ram #(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ROW_BITS+COL_BITS-1:0] addr,
  input  logic                         din,
  input  logic                         wr,
  input  logic                         cs,
  output logic                         dout,
  output logic                         dout_en
);
  localparam int ROWS  = 1 << ROW_BITS;
  localparam int COLS  = 1 << COL_BITS;
  localparam int CELLS = ROWS * COLS;

  logic [ROW_BITS-1:0] row_idx;
  logic [COL_BITS-1:0] col_idx;
  logic [ROWS-1:0]     row_sel;
  logic [COLS-1:0]     col_sel;
  logic [CELLS-1:0]    cells;
  logic [COLS-1:0]     col_rd;

  assign row_idx = addr[ROW_BITS+COL_BITS-1:COL_BITS];
  assign col_idx = addr[COL_BITS-1:0];

  genvar r, c;
  generate
    for (r = 0; r < ROWS; r++) begin : g_rowdec
      assign row_sel[r] = (row_idx == ROW_BITS'(r));
    end
    for (c = 0; c < COLS; c++) begin : g_coldec
      assign col_sel[c] = cs && (col_idx == COL_BITS'(c));
    end

    for (c = 0; c < COLS; c++) begin : g_col
      logic [ROWS-1:0] bitline;
      for (r = 0; r < ROWS; r++) begin : g_cell
        assign bitline[r] = cells[r*COLS+c];
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)
            cells[r*COLS+c] <= 1'b0;
          else if (col_sel[c] && row_sel[r] && wr)
            cells[r*COLS+c] <= din;
        end
      end
      assign col_rd[c] = col_sel[c] && !wr && |(bitline & row_sel);
    end
  endgenerate

  assign dout_en = cs && !wr;
  assign dout    = |col_rd;
endmodule

module csel_ram_chk #(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2
) (
  input logic                                       clk,
  input logic                                       rst_n,
  input logic [ROW_BITS+COL_BITS-1:0]               addr,
  input logic                                       wr,
  input logic                                       cs,
  input logic                                       dout,
  input logic                                       dout_en,
  input logic [(1<<ROW_BITS)-1:0]                   row_sel,
  input logic [(1<<COL_BITS)-1:0]                   col_sel,
  input logic [(1<<(ROW_BITS+COL_BITS))-1:0]        cells
);
  assert_col_onehot0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(col_sel));
  assert_col_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> col_sel == '0);
  assert_row_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(row_sel) == 1);
  assert_read_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> dout == cells[addr]);
  assert_quiet_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> !dout);
  assert_no_write_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> $stable(cells));
  assert_single_cell_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs && wr |=> $countones(cells ^ $past(cells)) <= 1);
  assert_read_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(cells));
endmodule

bind csel_ram csel_ram_chk #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .cs(cs), .dout(dout),
  .dout_en(dout_en), .row_sel(row_sel), .col_sel(col_sel), .cells(cells)
);

// File: tb/sim_csel_ram.sv
module sim_csel_ram;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] addr = '0;
  logic       din = 0, wr = 0, cs = 0;
  logic       dout, dout_en;
  logic [N-1:0] model;
  int total = 0, bad = 0;

  csel_ram u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .wr(wr),
               .cs(cs), .dout(dout), .dout_en(dout_en));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic write_cell(logic [3:0] a, logic d, logic sel);
    @(negedge clk);
    addr = a; din = d; wr = 1; cs = sel;
    #1;
    check("R6 dout_en in write", dout_en, 1'b0);
    check("R6 dout in write", dout, 1'b0);
    @(negedge clk);
    wr = 0; cs = 0;
    if (sel) model[a] = d;
  endtask

  task automatic read_all(string req);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      addr = 4'(i); wr = 0; cs = 1;
      #1;
      check({req, " R4 dout_en"}, dout_en, 1'b1);
      check({req, " R4 dout"}, dout, model[i]);
    end
    @(negedge clk);
    cs = 0;
  endtask

  task automatic t_reset;
    model = '0;
    read_all("R7 reset");
  endtask

  task automatic t_walk;
    for (int k = 0; k < N; k++) begin
      write_cell(4'(k), 1'b1, 1'b1);
      read_all("R1 R2 R3 walk");
      write_cell(4'(k), 1'b0, 1'b0 | 1'b1);
    end
  endtask

  task automatic t_cell9;
    write_cell(4'b1001, 1'b1, 1'b1);
    @(negedge clk);
    addr = 4'd9; cs = 1; wr = 0; #1;
    check("R1 cell 9", dout, 1'b1);
    addr = 4'd6; #1;
    check("R1 cell 6 (swapped fields)", dout, 1'b0);
    write_cell(4'b1001, 1'b0, 1'b1);
  endtask

  task automatic t_pattern;
    for (int i = 0; i < N; i++) write_cell(4'(i), logic'(i[0] ^ i[2] ^ i[3]), 1'b1);
    read_all("R2 pattern");
    for (int i = 0; i < N; i++) write_cell(4'(i), ~model[i], 1'b1);
    read_all("R2 inverse");
  endtask

  task automatic t_cs_low;
    for (int i = 0; i < N; i++) begin
      write_cell(4'(i), ~model[i], 1'b0);
      addr = 4'(i); #1;
      check("R5 dout_en cs low", dout_en, 1'b0);
      check("R5 dout cs low", dout, 1'b0);
    end
    read_all("R5 unchanged");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_cell9();
    t_walk();
    t_pattern();
    t_cs_low();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule